// File: doc/BRIEF.md
# Trace-Driven Bus Traffic Replayer

The replayer turns a recorded memory-access trace back into bus traffic. Trace records arrive one byte at a time over a valid/ready stream. Each record is gathered into a command. The replayer then waits the idle gap stored in the command and raises a request on a simple bus-master interface. The request can be an instruction fetch, a data read or a data write. An idle-only command produces no request; it only stalls the stream for its gap.

A command whose burst size is above one claims the records that follow it as extra data beats. The replayer issues the whole group as one burst request and holds it until the response strobe arrives. For reads, the returned data can optionally be compared against the recorded data words. A pending-work status and a finished flag let the surrounding environment tell when the trace has been fully replayed.

Top module: `trace_replay`

## Requirements
- R1: A record is twelve bytes. It is accepted on cycles where `in_valid` and `in_ready` are both high, and every multi-byte field comes most significant byte first. The fields, in arrival order, are: gap (16 bits), type (8 bits), burst size (8 bits), address (32 bits), data (32 bits).
- R2: Type 0x49 gives `req_kind`=0 (fetch), 0x52 gives 1 (read), 0x57 gives 2 (write) and 0x51 is the idle command.
- R3: For a fetch, read or write command with gap G, `req` rises exactly G cycles after the clock edge that accepts the command's final byte. With G=0 it is high right after that edge.
- R4: An idle command with gap G raises no request and holds `in_ready` low for exactly G cycles after its last byte is accepted.
- R5: A command with legal burst size N (1, 2, 4, 8, 16 or 32, not above MAX_BEATS) merges itself and the next N-1 records into one request. `req_beats`=N and `req_addr` is the head record's address. Beat i on `req_wdata[32*i +: 32]` holds the data word of record i. The gap, type, size and address of the follower records have no effect.
- R6: While `rsp_done` is low, `req` stays high with stable kind, address and beat count, and `in_ready` stays low. `req` falls on the edge that samples `rsp_done` high.
- R7: A head record with an unknown type, or a burst size that is not legal, sets the sticky `err_fmt`. That record alone is dropped: no request, no wait, and `in_ready` stays high.
- R8: When `cmp_en` is high and a read completes, any difference between the first N beats of `rsp_rdata` and the recorded words sets the sticky `err_cmp`. Writes, fetches, and reads with `cmp_en` low never set it.
- R9: `busy` is high while a record is partly received, follower records are still due, a gap is running or a request is outstanding. `done` equals `trace_end` and not `busy`.
- R10: After reset, `in_ready` is high and `req`, `busy`, `err_fmt` and `err_cmp` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Trace byte valid |
| in_data | input | 8 | Trace byte |
| in_ready | output | 1 | Replayer accepts a byte |
| trace_end | input | 1 | No more trace records will come |
| cmp_en | input | 1 | Enable read data comparison |
| req | output | 1 | Bus request |
| req_kind | output | 2 | 0 fetch, 1 read, 2 write |
| req_addr | output | 32 | Start address |
| req_beats | output | 6 | Beats in the transaction |
| req_wdata | output | 1024 | Beat data, beat i at bits 32*i upward |
| rsp_done | input | 1 | Response strobe ending the transaction |
| rsp_rdata | input | 1024 | Returned read beats, same layout |
| busy | output | 1 | Work in progress |
| done | output | 1 | Trace end seen and nothing pending |
| err_fmt | output | 1 | Sticky malformed record flag |
| err_cmp | output | 1 | Sticky read compare mismatch flag |

## Verification
Single-beat commands are replayed for every transfer kind against a ladder of gaps. This separates an exact gap count from an off-by-one, and one kind code from another. Bursts of 2, 4, 8 and 32 beats use follower records that carry garbage type, size, gap and address fields. These runs show that only the follower data words matter, and that each lands in the right beat slot. Idle commands with gaps from 0 to 300, delayed responses, read comparisons with and without mismatch, and malformed head records cover the stall, hold, flagging and skip paths.

// File: rtl/trace_replay.sv
module trace_replay #(
  parameter int MAX_BEATS = 32,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int GW = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [7:0]              in_data,
  output logic                    in_ready,
  input  logic                    trace_end,
  input  logic                    cmp_en,
  output logic                    req,
  output logic [1:0]              req_kind,
  output logic [AW-1:0]           req_addr,
  output logic [$clog2(MAX_BEATS):0] req_beats,
  output logic [MAX_BEATS*DW-1:0] req_wdata,
  input  logic                    rsp_done,
  input  logic [MAX_BEATS*DW-1:0] rsp_rdata,
  output logic                    busy,
  output logic                    done,
  output logic                    err_fmt,
  output logic                    err_cmp
);
  localparam int RW  = GW + 16 + AW + DW;
  localparam int NB  = RW / 8;
  localparam int BCW = $clog2(NB);
  localparam int NBW = $clog2(MAX_BEATS) + 1;
  localparam int IW  = $clog2(MAX_BEATS);
  localparam logic [7:0] TY_I = 8'h49, TY_R = 8'h52, TY_W = 8'h57, TY_Q = 8'h51;

  typedef enum logic [1:0] {ST_RX, ST_WAIT, ST_REQ} st_t;
  st_t st;

  logic [RW-9:0]  sh;
  logic [BCW-1:0] bcnt;
  logic [GW-1:0]  cnt, gap_q;
  logic [1:0]     kind_q;
  logic [AW-1:0]  addr_q;
  logic [NBW-1:0] beats_q, left_q;
  logic [IW-1:0]  idx_q;
  logic           idle_q;
  logic [DW-1:0]  wbuf [MAX_BEATS];

  wire take = in_valid && in_ready;
  wire last = take && (bcnt == BCW'(NB - 1));
  wire [RW-1:0] rec = {sh, in_data};

  wire [DW-1:0] r_data = rec[DW-1:0];
  wire [AW-1:0] r_addr = rec[AW+DW-1:DW];
  wire [7:0]    r_size = rec[AW+DW+7:AW+DW];
  wire [7:0]    r_type = rec[AW+DW+15:AW+DW+8];
  wire [GW-1:0] r_gap  = rec[RW-1:RW-GW];

  wire is_xfer  = (r_type == TY_I) || (r_type == TY_R) || (r_type == TY_W);
  wire size_ok  = (r_size != 8'd0) && ((r_size & (r_size - 8'd1)) == 8'd0)
                  && (int'(r_size) <= MAX_BEATS);
  wire head     = (left_q == '0);
  wire head_ok  = last && head && is_xfer && size_ok;
  wire do_go    = (head_ok && r_size == 8'd1) || (last && !head && left_q == NBW'(1));
  wire [GW-1:0] go_gap = head ? r_gap : gap_q;
  wire do_idle  = last && head && (r_type == TY_Q) && (r_gap != '0);
  wire bad_rec  = last && head && !is_xfer && (r_type != TY_Q) ||
                  last && head && is_xfer && !size_ok;

  logic mism;
  always_comb begin
    mism = 1'b0;
    for (int i = 0; i < MAX_BEATS; i++)
      if (i < int'(beats_q) && rsp_rdata[i*DW +: DW] != wbuf[i]) mism = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_RX; sh <= '0; bcnt <= '0; cnt <= '0; gap_q <= '0;
      kind_q <= '0; addr_q <= '0; beats_q <= NBW'(1); left_q <= '0;
      idx_q <= '0; idle_q <= 1'b0; err_fmt <= 1'b0; err_cmp <= 1'b0;
    end else begin
      if (take) begin
        sh   <= rec[RW-9:0];
        bcnt <= last ? '0 : bcnt + BCW'(1);
      end
      if (bad_rec) err_fmt <= 1'b1;
      if (head_ok) begin
        kind_q  <= (r_type == TY_I) ? 2'd0 : (r_type == TY_R) ? 2'd1 : 2'd2;
        addr_q  <= r_addr;
        gap_q   <= r_gap;
        beats_q <= r_size[NBW-1:0];
        left_q  <= r_size[NBW-1:0] - NBW'(1);
        idx_q   <= IW'(1);
      end
      if (last && !head) begin
        idx_q  <= idx_q + IW'(1);
        left_q <= left_q - NBW'(1);
      end
      case (st)
        ST_RX: begin
          if (do_go) begin
            idle_q <= 1'b0;
            if (go_gap == '0) st <= ST_REQ;
            else begin st <= ST_WAIT; cnt <= go_gap - GW'(1); end
          end else if (do_idle) begin
            idle_q <= 1'b1;
            st <= ST_WAIT;
            cnt <= r_gap - GW'(1);
          end
        end
        ST_WAIT: begin
          if (cnt == '0) st <= idle_q ? ST_RX : ST_REQ;
          else cnt <= cnt - GW'(1);
        end
        ST_REQ: begin
          if (rsp_done) begin
            st <= ST_RX;
            if (cmp_en && kind_q == 2'd1 && mism) err_cmp <= 1'b1;
          end
        end
        default: st <= ST_RX;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (head_ok) wbuf[0] <= r_data;
    else if (last && !head) wbuf[idx_q] <= r_data;
  end

  for (genvar g = 0; g < MAX_BEATS; g++) begin : g_wd
    assign req_wdata[g*DW +: DW] = wbuf[g];
  end

  assign in_ready  = (st == ST_RX);
  assign req       = (st == ST_REQ);
  assign req_kind  = kind_q;
  assign req_addr  = addr_q;
  assign req_beats = beats_q;
  assign busy      = (st != ST_RX) || (bcnt != '0) || (left_q != '0);
  assign done      = trace_end && !busy;

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req && !rsp_done |=> req && $stable(req_addr) && $stable(req_beats) && $stable(req_kind));
  // R6
  req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req && rsp_done |=> !req);
  // R6
  no_accept_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> !in_ready);
  // R5
  beats_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> $countones(req_beats) == 1);
  // R7
  fmt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_fmt |=> err_fmt);
  // R8
  cmp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_cmp |=> err_cmp);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready && !req);
endmodule

// File: tb/tb_trace_replay.sv
module tb_trace_replay;
  localparam int MB = 32;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, trace_end = 0, cmp_en = 0, rsp_done = 0;
  logic [7:0] in_data = 0;
  logic [MB*32-1:0] rsp_rdata = '0;
  logic in_ready, req, busy, done, err_fmt, err_cmp;
  logic [1:0] req_kind;
  logic [31:0] req_addr;
  logic [5:0] req_beats;
  logic [MB*32-1:0] req_wdata;

  trace_replay #(.MAX_BEATS(MB)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .trace_end(trace_end), .cmp_en(cmp_en), .req(req), .req_kind(req_kind),
    .req_addr(req_addr), .req_beats(req_beats), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .busy(busy), .done(done),
    .err_fmt(err_fmt), .err_cmp(err_cmp));

  always #2 clk = ~clk;

  int errs = 0, checks = 0, cyc = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; in_valid = 0; trace_end = 0; cmp_en = 0; rsp_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_data = b;
    @(posedge clk);
  endtask

  task automatic send_rec(input logic [15:0] gap, input logic [7:0] ty, input logic [7:0] sz,
                          input logic [31:0] a, input logic [31:0] d);
    logic [95:0] r;
    r = {gap, ty, sz, a, d};
    for (int i = 11; i >= 0; i--) send_byte(r[i*8 +: 8]);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic wait_req(output int n);
    n = 0;
    while (!req && n < 100000) begin n++; @(negedge clk); end
  endtask

  task automatic respond(input string tag);
    rsp_done = 1;
    @(negedge clk);
    rsp_done = 0;
    chk(!req && in_ready, tag, {62'd0, req, in_ready}, 64'd1);
  endtask

  function automatic logic [7:0] tcode(input int k);
    return (k == 0) ? 8'h49 : (k == 1) ? 8'h52 : 8'h57;
  endfunction

  function automatic logic [31:0] dword(input int s, input int i);
    return 32'hA5000000 ^ (s * 32'h10001) ^ (i * 32'h01030507);
  endfunction

  initial begin
    int n;
    int gaps[5] = '{0, 1, 2, 5, 17};
    int sizes[4] = '{2, 4, 8, 32};
    int qg[4] = '{0, 1, 4, 300};
    logic [31:0] a;
    logic sawreq;

    do_reset();
    // R10 reset state
    chk(in_ready && !req && !busy && !err_fmt && !err_cmp, "R10",
        {59'd0, in_ready, req, busy, err_fmt, err_cmp}, 64'h10);
    trace_end = 1; #1;
    chk(done, "R9 idle done", done, 1);
    trace_end = 0; #1;
    chk(!done, "R9 no end", done, 0);

    // R1 R2 R3 single-beat sweep
    for (int k = 0; k < 3; k++)
      for (int g = 0; g < 5; g++) begin
        a = 32'h1000_0000 + (k << 16) + (g << 4);
        send_rec(gaps[g], tcode(k), 8'd1, a, dword(k, g));
        wait_req(n);
        chk(n == gaps[g], "R3 gap", n, gaps[g]);
        chk(req_kind == k[1:0], "R2 kind", req_kind, k);
        chk(req_addr == a && req_beats == 6'd1, "R1 fields", {req_addr, 26'd0, req_beats}, {a, 32'd1});
        chk(req_wdata[31:0] == dword(k, g), "R1 data", req_wdata[31:0], dword(k, g));
        respond("R6 release");
      end

    // R5 bursts with junk follower fields
    foreach (sizes[s]) begin
      a = 32'h0002_1000 + s * 32'h100;
      send_rec(16'd3, 8'h57, sizes[s][7:0], a, dword(s, 0));
      for (int i = 1; i < sizes[s]; i++) begin
        if (s == 1 && i == 2) begin
          trace_end = 1; #1;
          chk(busy && !done, "R9 mid burst", {62'd0, busy, done}, 64'd2);
          trace_end = 0;
        end
        send_rec(16'hFFFF, 8'h00, 8'hFF, 32'hDEAD_0000 + i, dword(s, i));
      end
      wait_req(n);
      chk(n == 3, "R5 burst gap", n, 3);
      chk(req_beats == sizes[s][5:0] && req_addr == a && req_kind == 2'd2, "R5 header",
          {req_addr, 26'd0, req_beats}, {a, sizes[s][31:0]});
      chk(!err_fmt, "R5 followers ignored", err_fmt, 0);
      for (int i = 0; i < sizes[s]; i++)
        chk(req_wdata[i*32 +: 32] == dword(s, i), "R5 beat", req_wdata[i*32 +: 32], dword(s, i));
      respond("R6 burst release");
    end

    // R6 delayed response
    send_rec(16'd0, 8'h52, 8'd1, 32'h0000_BEE0, 32'd7);
    repeat (3) @(negedge clk);
    chk(req && !in_ready && req_addr == 32'h0000_BEE0, "R6 hold", {req_addr, 30'd0, req, in_ready},
        {32'h0000_BEE0, 32'd2});
    respond("R6 late release");

    // R4 idle command
    foreach (qg[q]) begin
      send_rec(qg[q][15:0], 8'h51, 8'd1, 32'h0, 32'h0);
      n = 0; sawreq = 0;
      while (!in_ready && n < 100000) begin sawreq |= req; n++; @(negedge clk); end
      chk(n == qg[q] && !sawreq, "R4 idle stall", n, qg[q]);
    end
    send_rec(16'd2, 8'h57, 8'd1, 32'h44, 32'h55);
    wait_req(n);
    chk(n == 2, "R4 after idle", n, 2);
    respond("R6 after idle");

    // R8 compare
    do_reset();
    cmp_en = 1;
    send_rec(16'd0, 8'h52, 8'd2, 32'h300, 32'h1111);
    send_rec(16'd0, 8'h00, 8'h00, 32'h0, 32'h2222);
    wait_req(n);
    rsp_rdata = '0; rsp_rdata[31:0] = 32'h1111; rsp_rdata[63:32] = 32'h2222;
    respond("R6 read");
    chk(!err_cmp, "R8 match", err_cmp, 0);
    send_rec(16'd0, 8'h57, 8'd1, 32'h304, 32'h9);
    wait_req(n);
    rsp_rdata[31:0] = 32'h0;
    respond("R6 write");
    chk(!err_cmp, "R8 write no compare", err_cmp, 0);
    send_rec(16'd0, 8'h52, 8'd2, 32'h300, 32'h1111);
    send_rec(16'd0, 8'h00, 8'h00, 32'h0, 32'h2222);
    wait_req(n);
    rsp_rdata[31:0] = 32'h1111; rsp_rdata[63:32] = 32'h2223;
    respond("R6 read2");
    chk(err_cmp, "R8 mismatch", err_cmp, 1);
    do_reset();
    cmp_en = 0;
    send_rec(16'd0, 8'h52, 8'd1, 32'h300, 32'h1111);
    wait_req(n);
    rsp_rdata[31:0] = 32'h0;
    respond("R6 read3");
    chk(!err_cmp, "R8 disabled", err_cmp, 0);

    // R7 malformed heads
    do_reset();
    send_rec(16'd9, 8'h41, 8'd1, 32'h0, 32'h0);
    chk(err_fmt && in_ready && !req, "R7 bad type", {61'd0, err_fmt, in_ready, req}, 64'h6);
    for (int v = 0; v < 3; v++) begin
      do_reset();
      send_rec(16'd9, 8'h57, (v == 0) ? 8'd3 : (v == 1) ? 8'd64 : 8'd0, 32'h0, 32'h0);
      chk(err_fmt && in_ready && !req, "R7 bad size", {61'd0, err_fmt, in_ready, req}, 64'h6);
    end
    send_rec(16'd1, 8'h49, 8'd1, 32'h7000, 32'h1);
    wait_req(n);
    chk(n == 1 && req_addr == 32'h7000, "R7 next record ok", req_addr, 32'h7000);
    respond("R6 final");
    trace_end = 1; #1;
    chk(done && !busy, "R9 done at end", {62'd0, done, busy}, 64'd2);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule